// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block connects an on-chip requester to an external asynchronous static RAM of 8192 bytes. The requester offers one access at a time over a valid/ready handshake that carries a 13-bit address, a byte of write data and a write flag. For a read, the block returns the byte on a one-cycle response strobe. On the RAM side it drives the address and two chip selects of opposite polarity: one active low and one active high. It also drives an active-low output enable and an active-low write strobe. The shared data bus is split into an output, a drive enable and an input.

The RAM has no clock. Every timing rule is therefore met by counting cycles of the controller clock. The length of each wait state is worked out at elaboration from the clock period parameter and from the chosen speed grade, which is a 70 ns part or a 100 ns part. After every read the controller waits a recovery interval, so that the RAM's output drivers have floated before the shared bus can be driven again.

Top module: `sram_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, the chip is deselected (active-low select high, active-high select low), the write strobe and output enable are high, the data driver is off, no response is raised, and the block is ready.
- R2: A request is taken on a clock edge where valid and ready are both high. Ready then stays low until the access and its recovery have ended: 1+RD+HZ cycles after acceptance for a read, and 2+WR cycles for a write.
- R3: Address, write data and write flag are registered when the request is taken. Changes on those inputs after that edge have no effect on the access in progress.
- R4: A read selects the chip with the write strobe high and the output enable low for exactly RD cycles. The byte on the data input is sampled at the edge that ends the read.
- R5: Each read produces exactly one response pulse, one cycle long, carrying the byte last written to that address (0 if never written). A write produces no response.
- R6: A write holds the chip selected, the write strobe low, the address stable and the data driven for exactly WR cycles. This covers the cycle time, select-to-end, write pulse and data setup limits.
- R7: A write ends with the write strobe and both selects released on the same edge. Address and data stay driven for one further cycle.
- R8: The data driver is never on while output enable is low. After a read it stays off for at least the RAM output-float time (HZ cycles).
- R9: Write strobe and output enable are never low together. Neither is low while the chip is deselected, and the chip is deselected whenever the block is ready.
- R10: Each wait count is the required time in ns divided by CLK_PERIOD_NS, rounded up, with a minimum of 1. With the defaults (5 ns clock, 70 ns grade) this gives RD=14, WR=14, HZ=5.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Controller clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Request offered |
| req_ready_o | output | 1 | Controller idle, request can be taken |
| req_we_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | 13 | Byte address |
| req_wdata_i | input | 8 | Write data |
| rsp_valid_o | output | 1 | One-cycle read data strobe |
| rsp_rdata_o | output | 8 | Read data |
| ram_addr_o | output | 13 | RAM address |
| ram_ce1_n_o | output | 1 | RAM select, active low |
| ram_ce2_o | output | 1 | RAM select, active high |
| ram_oe_n_o | output | 1 | RAM output enable, active low |
| ram_we_n_o | output | 1 | RAM write strobe, active low |
| ram_dq_o | output | 8 | Data toward the RAM |
| ram_dq_oe_o | output | 1 | Drive enable for ram_dq_o |
| ram_dq_i | input | 8 | Data from the RAM |

## Verification
The assertions assume that the requester keeps its request fields steady while valid is high and ready is low. They also assume that the RAM returns valid data only once its access time has passed. The stimulus changes request fields only one cycle after acceptance, and it fills them with the complement of the accepted values so that any late capture shows up. The bench RAM model returns the inverted byte until the access time has elapsed. It also keeps driving the bus for the float time after a read, so an early sample or an early bus drive turns into a visible data error or a contention report.

// File: rtl/sram_ctrl_pkg.sv
package sram_ctrl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_RD,
    ST_RD_FLT,
    ST_WR,
    ST_WR_END
  } st_e;

  // ceil(ns / period), at least one cycle
  function automatic int unsigned ns2cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(int unsigned a, int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_wait_timer.sv
module sram_wait_timer #(
  parameter int unsigned CW = 5
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          load_i,
  input  logic [CW-1:0] load_val_i,
  output logic          done_o
);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (load_i)           cnt_q <= load_val_i;
    else if (cnt_q != '0)      cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);

  // R10
  wait_not_short_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (load_i && load_val_i != '0) |=> !done_o);

endmodule

// File: rtl/sram_req_hold.sv
module sram_req_hold #(
  parameter int unsigned AW = 13,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          capture_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [DW-1:0] data_i,
  output logic          we_o,
  output logic [AW-1:0] addr_o,
  output logic [DW-1:0] data_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      we_o   <= 1'b0;
      addr_o <= '0;
      data_o <= '0;
    end else if (capture_i) begin
      we_o   <= we_i;
      addr_o <= addr_i;
      data_o <= data_i;
    end
  end

endmodule

// File: rtl/sram_ctrl.sv
module sram_ctrl
  import sram_ctrl_pkg::*;
#(
  parameter int unsigned AW            = 13,
  parameter int unsigned DW            = 8,
  parameter int unsigned CLK_PERIOD_NS = 5,
  parameter bit          SLOW_GRADE    = 1'b0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          req_valid_i,
  output logic          req_ready_o,
  input  logic          req_we_i,
  input  logic [AW-1:0] req_addr_i,
  input  logic [DW-1:0] req_wdata_i,
  output logic          rsp_valid_o,
  output logic [DW-1:0] rsp_rdata_o,
  output logic [AW-1:0] ram_addr_o,
  output logic          ram_ce1_n_o,
  output logic          ram_ce2_o,
  output logic          ram_oe_n_o,
  output logic          ram_we_n_o,
  output logic [DW-1:0] ram_dq_o,
  output logic          ram_dq_oe_o,
  input  logic [DW-1:0] ram_dq_i
);

  localparam int unsigned CYC_NS = SLOW_GRADE ? 100 : 70;
  localparam int unsigned ACC_NS = SLOW_GRADE ? 100 : 70;
  localparam int unsigned OEA_NS = SLOW_GRADE ? 50  : 40;
  localparam int unsigned WP_NS  = SLOW_GRADE ? 70  : 50;
  localparam int unsigned CW_NS  = SLOW_GRADE ? 90  : 65;
  localparam int unsigned DS_NS  = SLOW_GRADE ? 40  : 35;
  localparam int unsigned HZ_NS  = SLOW_GRADE ? 35  : 25;

  localparam int unsigned RD_CYC  = ns2cyc(max2(CYC_NS, max2(ACC_NS, OEA_NS)), CLK_PERIOD_NS);
  localparam int unsigned WR_CYC  = ns2cyc(max2(max2(CYC_NS, CW_NS), max2(WP_NS, DS_NS)), CLK_PERIOD_NS);
  localparam int unsigned HZ_CYC  = ns2cyc(HZ_NS, CLK_PERIOD_NS);
  localparam int unsigned CNT_MAX = max2(RD_CYC, max2(WR_CYC, HZ_CYC));
  localparam int unsigned TW      = $clog2(CNT_MAX + 1);

  st_e           st_q;
  logic          accept;
  logic          t_load;
  logic [TW-1:0] t_val;
  logic          t_done;
  logic          hold_we;

  assign req_ready_o = (st_q == ST_IDLE);
  assign accept      = req_valid_i && req_ready_o;

  sram_req_hold #(.AW(AW), .DW(DW)) u_hold (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .capture_i (accept),
    .we_i      (req_we_i),
    .addr_i    (req_addr_i),
    .data_i    (req_wdata_i),
    .we_o      (hold_we),
    .addr_o    (ram_addr_o),
    .data_o    (ram_dq_o)
  );

  always_comb begin
    t_load = 1'b0;
    t_val  = '0;
    if (accept) begin
      t_load = 1'b1;
      t_val  = req_we_i ? TW'(WR_CYC - 1) : TW'(RD_CYC - 1);
    end else if (st_q == ST_RD && t_done) begin
      t_load = 1'b1;
      t_val  = TW'(HZ_CYC - 1);
    end
  end

  sram_wait_timer #(.CW(TW)) u_timer (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (t_load),
    .load_val_i (t_val),
    .done_o     (t_done)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q        <= ST_IDLE;
      ram_ce1_n_o <= 1'b1;
      ram_ce2_o   <= 1'b0;
      ram_oe_n_o  <= 1'b1;
      ram_we_n_o  <= 1'b1;
      ram_dq_oe_o <= 1'b0;
      rsp_valid_o <= 1'b0;
      rsp_rdata_o <= '0;
    end else begin
      rsp_valid_o <= 1'b0;
      unique case (st_q)
        ST_IDLE: if (accept) begin
          ram_ce1_n_o <= 1'b0;
          ram_ce2_o   <= 1'b1;
          if (req_we_i) begin
            ram_we_n_o  <= 1'b0;
            ram_dq_oe_o <= 1'b1;
            st_q        <= ST_WR;
          end else begin
            ram_oe_n_o  <= 1'b0;
            st_q        <= ST_RD;
          end
        end
        ST_RD: if (t_done) begin
          rsp_rdata_o <= ram_dq_i;
          rsp_valid_o <= 1'b1;
          ram_ce1_n_o <= 1'b1;
          ram_ce2_o   <= 1'b0;
          ram_oe_n_o  <= 1'b1;
          st_q        <= ST_RD_FLT;
        end
        // RAM outputs still floating: keep own driver off
        ST_RD_FLT: if (t_done) st_q <= ST_IDLE;
        ST_WR: if (t_done) begin
          ram_we_n_o  <= 1'b1;
          ram_ce1_n_o <= 1'b1;
          ram_ce2_o   <= 1'b0;
          st_q        <= ST_WR_END;
        end
        ST_WR_END: begin
          ram_dq_oe_o <= 1'b0;
          st_q        <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  logic sel;
  assign sel = !ram_ce1_n_o && ram_ce2_o;

  // R2
  no_reaccept_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    accept |=> !req_ready_o);
  // R3
  wr_flag_match_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ram_we_n_o |-> hold_we);
  // R5
  rsp_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |=> !rsp_valid_o);
  // R5
  rsp_from_read_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> $past(!ram_oe_n_o) && ram_we_n_o);
  // R6
  addr_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel && $past(sel)) |-> $stable(ram_addr_o));
  // R6
  wdata_stable_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_we_n_o && $past(!ram_we_n_o)) |-> ($stable(ram_dq_o) && ram_dq_oe_o));
  // R7
  data_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(ram_we_n_o) |-> ram_dq_oe_o);
  // R8
  no_bus_fight_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ram_dq_oe_o |-> ram_oe_n_o);
  // R9
  strobe_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(!ram_oe_n_o && !ram_we_n_o));
  // R9
  strobe_sel_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!ram_oe_n_o || !ram_we_n_o) |-> sel);

endmodule

// File: tb/tb_sram_ctrl.sv
`timescale 1ns/100ps
module tb_sram_ctrl;

  localparam int P    = 5;
  localparam int T_RD = (70 + P - 1) / P;
  localparam int T_WR = (70 + P - 1) / P;
  localparam int T_HZ = (25 + P - 1) / P;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_we = 1'b0;
  logic [12:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [12:0] ram_addr;
  logic        ce1_n, ce2, oe_n, we_n, dq_oe;
  logic [7:0]  dq_o;
  logic [7:0]  dq_i = 8'h5a;

  int checks = 0, errors = 0;

  always #2.5 clk = ~clk;

  sram_ctrl #(.CLK_PERIOD_NS(P), .SLOW_GRADE(1'b0)) dut (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_we_i(req_we),
    .req_addr_i(req_addr), .req_wdata_i(req_wdata),
    .rsp_valid_o(rsp_valid), .rsp_rdata_o(rsp_rdata),
    .ram_addr_o(ram_addr), .ram_ce1_n_o(ce1_n), .ram_ce2_o(ce2),
    .ram_oe_n_o(oe_n), .ram_we_n_o(we_n),
    .ram_dq_o(dq_o), .ram_dq_oe_o(dq_oe), .ram_dq_i(dq_i)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s at %0t: actual %0h expected %0h", req, $time, act, exp);
    end
  endtask

  logic [7:0] ram_mem [int];
  logic [7:0] shadow  [int];

  function automatic logic [7:0] rd_ram(int a);
    return ram_mem.exists(a) ? ram_mem[a] : 8'h00;
  endfunction
  function automatic logic [7:0] rd_shadow(int a);
    return shadow.exists(a) ? shadow[a] : 8'h00;
  endfunction

  // RAM model and reference model, both evaluated mid-cycle
  int cyc = 0, free_at = 0, rsp_at = -1, rd_k = -1000, wr_k = -1000;
  logic [7:0] rsp_exp = '0;
  int rd_cnt = 0, hz_cnt = 0, w_cnt = 0, ds_cnt = 0;
  bit w_act = 0;
  logic [12:0] w_addr = '0, rd_addr = '0;
  logic [7:0]  w_data = '0;

  always @(negedge clk) begin
    bit sel, reading, writing;
    sel     = !ce1_n && ce2;
    reading = sel && we_n && !oe_n;
    writing = sel && !we_n;
    if (!rst_n) begin
      // R1
      chk(!sel && we_n && oe_n && !dq_oe && !rsp_valid && req_ready, "R1",
          {ce1_n, ce2, we_n, oe_n, dq_oe, rsp_valid, req_ready}, 7'b1011001);
    end else begin
      cyc++;
      // RAM: contention and strobe checks
      if (dq_oe && (reading || hz_cnt > 0)) chk(0, "R8 bus contention", dq_oe, 0);
      if (!oe_n && !we_n) chk(0, "R9 both strobes low", 1, 0);
      if (reading) begin
        if (rd_cnt > 0 && ram_addr != rd_addr) rd_cnt = 0;
        rd_addr = ram_addr;
        rd_cnt++;
        hz_cnt = T_HZ;
        dq_i = (rd_cnt * P >= 70) ? rd_ram(int'(ram_addr)) : ~rd_ram(int'(ram_addr));
      end else begin
        rd_cnt = 0;
        if (hz_cnt > 0) hz_cnt--;
        dq_i = 8'h5a;
      end
      if (writing) begin
        if (!w_act) begin
          w_act = 1; w_cnt = 0; ds_cnt = 0; w_addr = ram_addr;
        end else if (ram_addr != w_addr) chk(0, "R6 address moved in write", ram_addr, w_addr);
        w_cnt++;
        if (dq_oe && ds_cnt > 0 && dq_o == w_data) ds_cnt++;
        else if (dq_oe) begin ds_cnt = 1; w_data = dq_o; end
        else ds_cnt = 0;
      end else if (w_act) begin
        w_act = 0;
        chk(w_cnt * P >= 70, "R6 write pulse/cycle", w_cnt * P, 70);
        chk(ds_cnt * P >= 35, "R6 data setup", ds_cnt * P, 35);
        chk(dq_oe && dq_o == w_data && ram_addr == w_addr, "R7 hold", dq_o, w_data);
        ram_mem[int'(w_addr)] = w_data;
      end
      // reference model, compared on every clock
      chk(req_ready == (cyc >= free_at), "R2 ready", req_ready, cyc >= free_at);
      if (cyc >= free_at) chk(!sel && !dq_oe, "R9 idle deselected", {sel, dq_oe}, 0);
      chk(rsp_valid == (cyc == rsp_at), "R5 rsp_valid", rsp_valid, cyc == rsp_at);
      if (cyc == rsp_at) chk(rsp_rdata == rsp_exp, "R5 R3 read data", rsp_rdata, rsp_exp);
      // R4 R10: read window length
      chk(reading == (cyc > rd_k && cyc <= rd_k + T_RD), "R4/R10 read window", reading,
          cyc > rd_k && cyc <= rd_k + T_RD);
      // R6 R10: write window length
      chk(writing == (cyc > wr_k && cyc <= wr_k + T_WR), "R6/R10 write window", writing,
          cyc > wr_k && cyc <= wr_k + T_WR);
      if (req_valid && req_ready) begin
        if (req_we) begin
          shadow[int'(req_addr)] = req_wdata;
          wr_k    = cyc;
          free_at = cyc + 2 + T_WR;
        end else begin
          rd_k    = cyc;
          rsp_at  = cyc + 1 + T_RD;
          rsp_exp = rd_shadow(int'(req_addr));
          free_at = cyc + 1 + T_RD + T_HZ;
        end
      end
    end
  end

  // R3: inputs are scrambled right after acceptance
  task automatic do_req(input bit we, input logic [12:0] a, input logic [7:0] d);
    @(posedge clk); #1;
    req_valid = 1'b1; req_we = we; req_addr = a; req_wdata = d;
    do @(negedge clk); while (!req_ready);
    @(posedge clk); #1;
    req_valid = 1'b0; req_we = ~we; req_addr = ~a; req_wdata = ~d;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    // boundaries of the address space
    do_req(1, 13'h0000, 8'h11);
    do_req(1, 13'h1fff, 8'hee);
    do_req(0, 13'h0000, 8'h00);
    do_req(0, 13'h1fff, 8'h00);
    do_req(0, 13'h0064, 8'h00);
    // write directly after read: turnaround
    do_req(0, 13'h0005, 8'h00);
    do_req(1, 13'h0005, 8'h3c);
    do_req(0, 13'h0005, 8'h00);
    do_req(1, 13'h0005, 8'hc3);
    do_req(1, 13'h0006, 8'h77);
    do_req(0, 13'h0005, 8'h00);
    do_req(0, 13'h0006, 8'h00);
    for (int i = 0; i < 300; i++) begin
      logic [12:0] a;
      a = ($urandom_range(0, 1) == 0) ? 13'($urandom_range(0, 15))
                                       : 13'($urandom_range(8180, 8191));
      repeat ($urandom_range(0, 3)) @(posedge clk);
      do_req(1'($urandom_range(0, 1)), a, 8'($urandom));
    end
    repeat (40) @(posedge clk);
    finish_run();
  end

endmodule